// File: doc/BRIEF.md
# Per-process page table translator

This block turns a 20-bit virtual address into an 18-bit physical address through a page table held on chip. The bottom 14 bits are the offset inside a 16 KB page and pass straight through. The top 6 bits pick one of 64 entries in the table of the process named on the request. There are four process tables, so the same virtual page can map to different frames in different processes. An entry either maps the page to one of 16 resident frames, or holds the disk sector where the page currently lives.

A lookup answers one cycle later. On a hit it returns the physical address. On a miss it raises a page fault and returns the sector number. It also nominates the resident page of that process that has gone longest without use, which becomes the page to evict. Each entry keeps a last-used stamp for this purpose, taken from a free-running counter.

Tables change only through the privileged update port. That port has two operations. A plain entry write sets one entry. A page-in hands the frame of the victim entry to the faulting entry and parks the victim on its disk sector.

Top module: `pgx_translator`

## Requirements
- R1: A lookup request is answered in the following cycle with `rsp_valid` high. On a valid entry the answer has `rsp_hit`=1, `rsp_fault`=0 and `rsp_pa` = {frame, va[13:0]}. A cycle with no request gives `rsp_valid`=0.
- R2: A lookup of an entry whose valid bit is clear gives `rsp_fault`=1, `rsp_hit`=0, `rsp_pa`=0, and `rsp_sector` = the 12-bit sector stored in that entry.
- R3: The table is chosen by the 2-bit process number. A given virtual page maps independently in each of the four processes.
- R4: On a fault the victim is the valid entry of the same process with the greatest age. Age is the counter value minus the entry's stamp, taken modulo 2^16. A tie goes to the lowest VPN. If the process has no valid entry, `rsp_victim_ok`=0. On a hit, `rsp_victim_ok`=0 and `rsp_victim_vpn`=0.
- R5: A lookup that hits sets that entry's stamp to the current counter value. A lookup that faults leaves every stamp unchanged.
- R6: The write operation (`upd_op`=0) stores `upd_valid` and `upd_data` in the entry {`upd_pid`, `upd_vpn`} and stamps it with the current counter value.
- R7: The page-in operation (`upd_op`=1) has two effects. The victim entry `upd_vpn2` becomes invalid with sector `upd_data` and keeps its stamp. The faulting entry `upd_vpn` becomes valid with the victim's old frame and is stamped with the current counter value.
- R8: After reset, every entry in every table is invalid with sector 0 and stamp 0, the counter is 0, and all response outputs are 0.
- R9: A lookup and an update in the same cycle are both handled. The lookup is answered from the table as it stood before the update. When both touch the same entry, the update's stamp and contents win.
- R10: For a valid entry the frame is `upd_data[3:0]`; the upper 8 bits of the stored field are ignored by translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_pid | input | 2 | Process number of the lookup |
| lk_va | input | 20 | Virtual address |
| upd_en | input | 1 | Privileged update strobe |
| upd_op | input | 1 | 0 = entry write, 1 = page-in |
| upd_pid | input | 2 | Process table being updated |
| upd_vpn | input | 6 | Entry written, or faulting entry for a page-in |
| upd_vpn2 | input | 6 | Victim entry for a page-in |
| upd_valid | input | 1 | Valid bit for an entry write |
| upd_data | input | 12 | Frame (low 4 bits) or disk sector |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Page fault |
| rsp_pa | output | 18 | Physical address on a hit |
| rsp_sector | output | 12 | Disk sector on a fault |
| rsp_victim_ok | output | 1 | A victim page was found |
| rsp_victim_vpn | output | 6 | VPN of the least recently used resident page |

## Verification
A lookup and a privileged update can land in the same cycle, even on the same entry. The bench provokes this with directed cases: it looks up an entry while rewriting it, and while invalidating it. The random phase also confines addresses to a few pages, so that collisions recur. The bench judges each answer against a model that answers from the table before the update. The model then applies the hit refresh and the update in that order, so later lookups and victim choices reveal whether the update's stamp won.

// File: rtl/pgx_pkg.sv
// Shared sizes and the page table entry layout for the translator.
package pgx_pkg;
    localparam int VA_W   = 20;
    localparam int OFF_W  = 14;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 4;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int SEC_W  = 12;
    localparam int PID_W  = 2;
    localparam int NPROC  = 1 << PID_W;
    localparam int NPAGE  = 1 << VPN_W;
    localparam int NENT   = NPROC * NPAGE;
    localparam int TS_W   = 16;

    // One entry: frame in body[PPN_W-1:0] when valid, else disk sector.
    typedef struct packed {
        logic             valid;
        logic [SEC_W-1:0] body;
        logic [TS_W-1:0]  stamp;
    } pte_t;
endpackage

// File: rtl/pgx_table.sv
// Page table storage for all processes.
// Presents the whole table of one process for reading and applies the
// stamp refresh and the privileged updates. Assumes a page-in names a
// valid victim distinct from the faulting entry. Update beats refresh.
module pgx_table
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PID_W-1:0]  rd_pid,
    output pte_t              row [NPAGE],
    input  logic [TS_W-1:0]   now,
    input  logic              touch_en,
    input  logic [PID_W-1:0]  touch_pid,
    input  logic [VPN_W-1:0]  touch_vpn,
    input  logic              upd_en,
    input  logic              upd_op,
    input  logic [PID_W-1:0]  upd_pid,
    input  logic [VPN_W-1:0]  upd_vpn,
    input  logic [VPN_W-1:0]  upd_vpn2,
    input  logic              upd_valid,
    input  logic [SEC_W-1:0]  upd_data
);
    pte_t mem [NENT];

    logic [PID_W+VPN_W-1:0] t_idx, u_idx, v_idx;
    logic [SEC_W-1:0]       freed;

    assign t_idx = {touch_pid, touch_vpn};
    assign u_idx = {upd_pid, upd_vpn};
    assign v_idx = {upd_pid, upd_vpn2};
    assign freed = {{(SEC_W-PPN_W){1'b0}}, mem[v_idx].body[PPN_W-1:0]};

    // Expose the selected process table.
    always_comb begin
        for (int v = 0; v < NPAGE; v++)
            row[v] = mem[{rd_pid, VPN_W'(v)}];
    end

    // Clear on reset, then refresh stamps and apply updates (update last).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++)
                mem[i] <= '0;
        end else begin
            if (touch_en)
                mem[t_idx].stamp <= now;
            if (upd_en) begin
                if (!upd_op) begin
                    mem[u_idx] <= '{valid: upd_valid, body: upd_data, stamp: now};
                end else begin
                    mem[v_idx] <= '{valid: 1'b0, body: upd_data, stamp: mem[v_idx].stamp};
                    mem[u_idx] <= '{valid: 1'b1, body: freed, stamp: now};
                end
            end
        end
    end
endmodule

// File: rtl/pgx_lru.sv
// Least-recently-used victim search over one process table.
// Age is now minus stamp modulo 2^TS_W; the first (lowest VPN) entry of
// greatest age wins. Assumes stamps are younger than 2^TS_W cycles.
module pgx_lru
    import pgx_pkg::*;
(
    input  pte_t              row [NPAGE],
    input  logic [TS_W-1:0]   now,
    output logic              found,
    output logic [VPN_W-1:0]  vpn
);
    logic [TS_W-1:0] best_age, age;

    // Linear scan keeping the oldest valid entry.
    always_comb begin
        found    = 1'b0;
        vpn      = '0;
        best_age = '0;
        age      = '0;
        for (int v = 0; v < NPAGE; v++) begin
            age = now - row[v].stamp;
            if (row[v].valid && (!found || age > best_age)) begin
                found    = 1'b1;
                vpn      = VPN_W'(v);
                best_age = age;
            end
        end
    end
endmodule

// File: rtl/pgx_translator.sv
// Virtual-to-physical translator with per-process tables.
// Registers a one-cycle answer to each lookup: physical address on a hit,
// sector plus LRU victim on a fault. Lookups read the table before any
// same-cycle update. Reset is synchronous and active low.
module pgx_translator
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              upd_en,
    input  logic              upd_op,
    input  logic [PID_W-1:0]  upd_pid,
    input  logic [VPN_W-1:0]  upd_vpn,
    input  logic [VPN_W-1:0]  upd_vpn2,
    input  logic              upd_valid,
    input  logic [SEC_W-1:0]  upd_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [SEC_W-1:0]  rsp_sector,
    output logic              rsp_victim_ok,
    output logic [VPN_W-1:0]  rsp_victim_vpn
);
    logic [TS_W-1:0]  now;
    pte_t             row [NPAGE];
    pte_t             ent;
    logic [VPN_W-1:0] vpn;
    logic             hit, vic_found;
    logic [VPN_W-1:0] vic_vpn;

    assign vpn = lk_va[VA_W-1:OFF_W];
    assign ent = row[vpn];
    assign hit = lk_req && ent.valid;

    // Free-running last-used time base.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    pgx_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pid    (lk_pid),
        .row       (row),
        .now       (now),
        .touch_en  (hit),
        .touch_pid (lk_pid),
        .touch_vpn (vpn),
        .upd_en    (upd_en),
        .upd_op    (upd_op),
        .upd_pid   (upd_pid),
        .upd_vpn   (upd_vpn),
        .upd_vpn2  (upd_vpn2),
        .upd_valid (upd_valid),
        .upd_data  (upd_data)
    );

    pgx_lru u_lru (
        .row   (row),
        .now   (now),
        .found (vic_found),
        .vpn   (vic_vpn)
    );

    // Register the lookup answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_pa         <= '0;
            rsp_sector     <= '0;
            rsp_victim_ok  <= 1'b0;
            rsp_victim_vpn <= '0;
        end else begin
            rsp_valid      <= lk_req;
            rsp_hit        <= hit;
            rsp_fault      <= lk_req && !ent.valid;
            rsp_pa         <= hit ? {ent.body[PPN_W-1:0], lk_va[OFF_W-1:0]} : '0;
            rsp_sector     <= (lk_req && !ent.valid) ? ent.body : '0;
            rsp_victim_ok  <= lk_req && !ent.valid && vic_found;
            rsp_victim_vpn <= (lk_req && !ent.valid && vic_found) ? vic_vpn : '0;
        end
    end
endmodule

// File: rtl/pgx_checker.sv
// Temporal checks on the translator ports; bound to every instance.
module pgx_checker
    import pgx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_va,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_victim_ok,
    input logic [VPN_W-1:0]  rsp_victim_vpn
);
    // R1
    answer_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    // R1
    no_answer_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    // R1
    offset_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!rsp_hit || rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));
    // R2
    hit_fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault));
    // R2
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_pa == '0);
    // R4
    victim_only_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_victim_ok |-> rsp_fault);
    // R4
    victim_vpn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_victim_ok |-> rsp_victim_vpn == '0);
endmodule

bind pgx_translator pgx_checker u_pgx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_req         (lk_req),
    .lk_va          (lk_va),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_fault      (rsp_fault),
    .rsp_pa         (rsp_pa),
    .rsp_victim_ok  (rsp_victim_ok),
    .rsp_victim_vpn (rsp_victim_vpn)
);

// File: tb/test_pgx_translator.sv
// Bench: directed corner cases then seeded random traffic, scored against
// a behavioural table model kept in the bench.
module test_pgx_translator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0;
    logic [1:0]  lk_pid = 0;
    logic [19:0] lk_va = 0;
    logic        upd_en = 0, upd_op = 0, upd_valid = 0;
    logic [1:0]  upd_pid = 0;
    logic [5:0]  upd_vpn = 0, upd_vpn2 = 0;
    logic [11:0] upd_data = 0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_victim_ok;
    logic [17:0] rsp_pa;
    logic [11:0] rsp_sector;
    logic [5:0]  rsp_victim_vpn;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] tnow = 0;

    bit          mv [4][64];
    logic [11:0] md [4][64];
    logic [15:0] mt [4][64];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench copy of the time base, advanced on each edge out of reset.
    always @(posedge clk) tnow <= rst_n ? tnow + 16'd1 : 16'd0;

    pgx_translator i_pgx_translator (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pid(lk_pid), .lk_va(lk_va),
        .upd_en(upd_en), .upd_op(upd_op), .upd_pid(upd_pid), .upd_vpn(upd_vpn),
        .upd_vpn2(upd_vpn2), .upd_valid(upd_valid), .upd_data(upd_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .rsp_sector(rsp_sector), .rsp_victim_ok(rsp_victim_ok),
        .rsp_victim_vpn(rsp_victim_vpn)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Oldest valid entry of a process at time t (R4).
    function automatic int lru_of(input int p, input logic [15:0] t);
        int best = -1;
        logic [15:0] ba = 0;
        for (int v = 0; v < 64; v++) begin
            logic [15:0] a = t - mt[p][v];
            if (mv[p][v] && (best < 0 || a > ba)) begin best = v; ba = a; end
        end
        return best;
    endfunction

    // One cycle: drive at negedge, score at the next negedge, model updates.
    task automatic step(input bit lk, input int pid, input logic [19:0] va,
                        input bit up, input bit op, input int upid, input int uv,
                        input int uv2, input bit uval, input logic [11:0] ud,
                        input string tag);
        logic [15:0] st = tnow;
        int vp = va[19:14];
        bit e_hit = 0, e_vok = 0;
        logic [17:0] e_pa = 0;
        logic [11:0] e_sec = 0;
        int vic = -1;
        string t;
        lk_req = lk; lk_pid = 2'(pid); lk_va = va;
        upd_en = up; upd_op = op; upd_pid = 2'(upid); upd_vpn = 6'(uv);
        upd_vpn2 = 6'(uv2); upd_valid = uval; upd_data = ud;
        if (lk) begin
            e_hit = mv[pid][vp];
            if (e_hit) e_pa = {md[pid][vp][3:0], va[13:0]};
            else begin
                e_sec = md[pid][vp];
                vic = lru_of(pid, st);
                e_vok = (vic >= 0);
            end
            if (e_hit) mt[pid][vp] = st;
        end
        if (up) begin
            if (!op) begin
                mv[upid][uv] = uval; md[upid][uv] = ud; mt[upid][uv] = st;
            end else begin
                logic [3:0] fr = md[upid][uv2][3:0];
                mv[upid][uv2] = 0; md[upid][uv2] = ud;
                mv[upid][uv] = 1; md[upid][uv] = {8'h0, fr}; mt[upid][uv] = st;
            end
        end
        @(posedge clk);
        @(negedge clk);
        t = (tag != "") ? tag : (e_hit ? "R1" : "R2");
        chk(rsp_valid == lk, t, "valid", rsp_valid, lk);
        if (lk) begin
            chk(rsp_hit == e_hit && rsp_fault == !e_hit, t, "hit", rsp_hit, e_hit);
            chk(rsp_pa == e_pa, t, "pa", rsp_pa, e_pa);
            chk(rsp_sector == e_sec, t, "sector", rsp_sector, e_sec);
            chk(rsp_victim_ok == e_vok, (tag != "") ? tag : "R4", "victim_ok", rsp_victim_ok, e_vok);
            if (e_vok)
                chk(rsp_victim_vpn == 6'(vic), (tag != "") ? tag : "R4", "victim", rsp_victim_vpn, vic);
        end
        lk_req = 0; upd_en = 0;
    endtask

    task automatic look(input int pid, input int vp, input string tag);
        step(1, pid, {6'(vp), 14'h2A5C ^ 14'(vp)}, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int pid, input int vp, input bit val, input logic [11:0] d);
        step(0, 0, 0, 1, 0, pid, vp, 0, val, d, "R6");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < 4; p++)
            for (int v = 0; v < 64; v++) begin mv[p][v] = 0; md[p][v] = 0; mt[p][v] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8: quiet outputs, empty tables
        chk(!rsp_valid && !rsp_hit && rsp_pa == 0, "R8", "reset outputs", rsp_valid, 0);
        look(0, 0, "R8");
        look(3, 63, "R8");
        // R6 / R1 / R10: upper bits of a valid field ignored
        wr(1, 5, 1, 12'hAB7);
        look(1, 5, "R10");
        // R3: same VPN, other process
        wr(2, 5, 1, 12'h003);
        look(2, 5, "R3");
        look(1, 5, "R3");
        look(0, 5, "R3");
        // R2 / R4: sector fault, single resident page as victim
        wr(1, 9, 0, 12'h4D2);
        look(1, 9, "R2");
        wr(1, 6, 1, 12'h001);
        look(1, 9, "R4");
        // R5: refresh vpn 5 so vpn 6 becomes oldest; fault leaves stamps
        look(1, 5, "R5");
        look(1, 9, "R5");
        look(1, 9, "R5");
        // R7: page vpn 9 into vpn 6's frame
        step(0, 0, 0, 1, 1, 1, 9, 6, 0, 12'h111, "R7");
        look(1, 9, "R7");
        look(1, 6, "R7");
        // R9: lookup while rewriting, then while invalidating the same entry
        step(1, 1, {6'd5, 14'h0100}, 1, 0, 1, 5, 0, 1, 12'h002, "R9");
        look(1, 5, "R9");
        step(1, 1, {6'd5, 14'h3FFF}, 1, 0, 1, 5, 0, 0, 12'h777, "R9");
        look(1, 5, "R9");
        look(1, 9, "R9");
        // Random traffic on a few pages so collisions recur
        for (int k = 0; k < 4000; k++) begin
            int p = $urandom % 4, v = $urandom % 8, up = $urandom % 3;
            logic [19:0] va = {6'(v), 14'($urandom)};
            if (up == 2) begin
                int up_p = $urandom % 4, f = -1, vic = lru_of(up_p, tnow);
                for (int s = 0; s < 8; s++) if (!mv[up_p][s] && f < 0) f = s;
                if (vic >= 0 && f >= 0)
                    step($urandom % 2, p, va, 1, 1, up_p, f, vic, 0, 12'($urandom), "");
                else
                    step(1, p, va, 1, 0, up_p, $urandom % 8, 0, 1, 12'($urandom), "");
            end else if (up == 1)
                step($urandom % 2, p, va, 1, 0, $urandom % 4, $urandom % 8, 0,
                     ($urandom % 3) != 0, 12'($urandom), "");
            else
                step(1, p, va, 0, 0, 0, 0, 0, 0, 0, "");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule